// File: doc/BRIEF.md
# Dual-Port Memory with Cross-Port Mailbox Interrupts

This block is a synchronous two-port word memory in which the two highest addresses double as mailboxes. Port A owns the word at address `2^AW-2` and port B owns the word at `2^AW-1`. When one port writes the other port's mailbox word, the owner's interrupt flag is raised. The owner lowers the flag again by accessing its own mailbox word with chip select and output enable both active. The value written into a mailbox is kept as ordinary data, so it can carry a message for the owner to read.

With the full 15-bit address width, the two mailboxes sit at 0x7FFE (port A) and 0x7FFF (port B). The default width is smaller so that the behavioural array stays compact; the mailbox addresses follow the width. Setting `MBOX_EN` to 0 removes the interrupt function. The two words then act as plain storage and both interrupt outputs stay inactive.

All control inputs are active low. The interrupt outputs are active low and registered. A set and a clear of the same flag in the same cycle resolve in favour of the set.

Top module: `xport_mailbox_ram`

## Requirements
- R1: After reset, `a_irq_n` and `b_irq_n` are 1 and both read-data outputs are 0.
- R2: A port B write (`b_cs_n`=0, `b_we_n`=0) to address `2^AW-2` drives `a_irq_n` to 0 after that clock edge.
- R3: A port A access with `a_cs_n`=0 and `a_oe_n`=0 at address `2^AW-2` drives `a_irq_n` to 1 after that edge, whatever `a_we_n` is.
- R4: A port A write (`a_cs_n`=0, `a_we_n`=0) to address `2^AW-1` drives `b_irq_n` to 0 after that clock edge.
- R5: A port B access with `b_cs_n`=0 and `b_oe_n`=0 at address `2^AW-1` drives `b_irq_n` to 1 after that edge, whatever `b_we_n` is.
- R6: When the set of a flag and its clear fall in the same cycle, the flag ends up asserted (its output is 0).
- R7: Mailbox words keep written data, and a read returns that data like any other word.
- R8: With `MBOX_EN`=0, both interrupt outputs stay 1 under any stimulus, and all addresses, the top two included, behave as plain storage.
- R9: A write (`cs_n`=0, `we_n`=0) stores `wdata` at the clock edge. A read (`cs_n`=0, `we_n`=1, `oe_n`=0) loads `rdata` at the edge with the word as it was before that edge's writes. Outside a read, `rdata` holds its value. When both ports write the same address in one cycle, port A's data is kept.
- R10: An interrupt flag changes only through R2 to R6. An owner access with `oe_n`=1, or an owner access to any other address, leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_we_n | input | 1 | Port A write strobe, active low |
| a_addr | input | AW | Port A word address |
| a_wdata | input | DW | Port A write data |
| a_rdata | output | DW | Port A registered read data |
| a_irq_n | output | 1 | Port A interrupt, active low |
| b_cs_n | input | 1 | Port B chip select, active low |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_we_n | input | 1 | Port B write strobe, active low |
| b_addr | input | AW | Port B word address |
| b_wdata | input | DW | Port B write data |
| b_rdata | output | DW | Port B registered read data |
| b_irq_n | output | 1 | Port B interrupt, active low |

## Verification
The partner's write that raises a flag and the owner's access that lowers it can land on the same clock edge. The bench provokes this directly: port B writes `2^AW-2` in the same cycle that port A reads it, and the reverse is done for the other flag. Random cycles aimed heavily at the two mailbox addresses then repeat the collision many times. Each outcome is judged against a bench model that applies the set before the clear, so the flag must stay asserted, and the data read in that cycle must be the word as it was before the write.

// File: rtl/xport_mailbox_ram.sv
module xport_mailbox_ram #(
  parameter int AW      = 10,
  parameter int DW      = 16,
  parameter bit MBOX_EN = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_cs_n,
  input  logic          a_oe_n,
  input  logic          a_we_n,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          a_irq_n,
  input  logic          b_cs_n,
  input  logic          b_oe_n,
  input  logic          b_we_n,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          b_irq_n
);

  localparam int          DEPTH = 1 << AW;
  localparam logic [AW-1:0] MB_A = {{(AW-1){1'b1}}, 1'b0};
  localparam logic [AW-1:0] MB_B = {AW{1'b1}};

  logic [DW-1:0] mem [DEPTH];

  logic a_wr, b_wr, a_rd, b_rd, a_sel, b_sel, same_wr;
  assign a_wr    = !a_cs_n && !a_we_n;
  assign b_wr    = !b_cs_n && !b_we_n;
  assign a_rd    = !a_cs_n &&  a_we_n && !a_oe_n;
  assign b_rd    = !b_cs_n &&  b_we_n && !b_oe_n;
  assign a_sel   = !a_cs_n && !a_oe_n;
  assign b_sel   = !b_cs_n && !b_oe_n;
  assign same_wr = a_wr && b_wr && (a_addr == b_addr);

  always_ff @(posedge clk) begin
    if (b_wr && !same_wr) mem[b_addr] <= b_wdata;
    if (a_wr)             mem[a_addr] <= a_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rdata <= '0;
      b_rdata <= '0;
    end else begin
      if (a_rd) a_rdata <= mem[a_addr];
      if (b_rd) b_rdata <= mem[b_addr];
    end
  end

  generate
    if (MBOX_EN) begin : g_mbox
      logic a_flag, b_flag;
      logic set_a, clr_a, set_b, clr_b;
      assign set_a = b_wr  && (b_addr == MB_A);
      assign clr_a = a_sel && (a_addr == MB_A);
      assign set_b = a_wr  && (a_addr == MB_B);
      assign clr_b = b_sel && (b_addr == MB_B);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          a_flag <= 1'b0;
          b_flag <= 1'b0;
        end else begin
          if (set_a)      a_flag <= 1'b1;
          else if (clr_a) a_flag <= 1'b0;
          if (set_b)      b_flag <= 1'b1;
          else if (clr_b) b_flag <= 1'b0;
        end
      end

      assign a_irq_n = !a_flag;
      assign b_irq_n = !b_flag;

      // R2
      a_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!b_cs_n && !b_we_n && b_addr == MB_A) |=> !a_irq_n);
      // R4
      b_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_cs_n && !a_we_n && a_addr == MB_B) |=> !b_irq_n);
      // R3
      a_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_cs_n && !a_oe_n && a_addr == MB_A &&
         !(!b_cs_n && !b_we_n && b_addr == MB_A)) |=> a_irq_n);
      // R5
      b_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!b_cs_n && !b_oe_n && b_addr == MB_B &&
         !(!a_cs_n && !a_we_n && a_addr == MB_B)) |=> b_irq_n);
      // R10
      a_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(a_irq_n) |-> $past(!a_cs_n && !a_oe_n && a_addr == MB_A));
      // R10
      b_fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(b_irq_n) |-> $past(!a_cs_n && !a_we_n && a_addr == MB_B));
    end else begin : g_plain
      assign a_irq_n = 1'b1;
      assign b_irq_n = 1'b1;
    end
  endgenerate

endmodule

// File: tb/xport_mailbox_ram_bench.sv
module xport_mailbox_ram_bench;
  localparam int AW = 10;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] MB_A = DEPTH - 2;
  localparam logic [AW-1:0] MB_B = DEPTH - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic a_cs_n = 1, a_oe_n = 1, a_we_n = 1, b_cs_n = 1, b_oe_n = 1, b_we_n = 1;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0;
  logic [DW-1:0] a_rdata, b_rdata, o_a_rdata, o_b_rdata;
  logic a_irq_n, b_irq_n, o_a_irq_n, o_b_irq_n;

  xport_mailbox_ram #(.AW(AW), .DW(DW), .MBOX_EN(1'b1)) u_xport_mailbox_ram (
    .clk, .rst_n, .a_cs_n, .a_oe_n, .a_we_n, .a_addr, .a_wdata, .a_rdata, .a_irq_n,
    .b_cs_n, .b_oe_n, .b_we_n, .b_addr, .b_wdata, .b_rdata, .b_irq_n);

  xport_mailbox_ram #(.AW(AW), .DW(DW), .MBOX_EN(1'b0)) u_xport_mailbox_ram_off (
    .clk, .rst_n, .a_cs_n, .a_oe_n, .a_we_n, .a_addr, .a_wdata,
    .a_rdata(o_a_rdata), .a_irq_n(o_a_irq_n),
    .b_cs_n, .b_oe_n, .b_we_n, .b_addr, .b_wdata,
    .b_rdata(o_b_rdata), .b_irq_n(o_b_irq_n));

  int n_cmp = 0, n_bad = 0;
  logic [DW-1:0] m_mem [DEPTH];
  logic [DW-1:0] e_ra = '0, e_rb = '0;
  logic e_fa = 1'b0, e_fb = 1'b0;

  task automatic check(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
    if ($isunknown(exp)) return;
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic flag_next(logic cur, logic set, logic clr);
    return set ? 1'b1 : (clr ? 1'b0 : cur);
  endfunction

  task automatic step(input logic acs, aoe, awe, input logic [AW-1:0] aad, input logic [DW-1:0] awd,
                      input logic bcs, boe, bwe, input logic [AW-1:0] bad, input logic [DW-1:0] bwd,
                      input string tag);
    logic awr, bwr;
    a_cs_n = acs; a_oe_n = aoe; a_we_n = awe; a_addr = aad; a_wdata = awd;
    b_cs_n = bcs; b_oe_n = boe; b_we_n = bwe; b_addr = bad; b_wdata = bwd;
    awr = !acs && !awe;
    bwr = !bcs && !bwe;
    if (!acs && awe && !aoe) e_ra = m_mem[aad];
    if (!bcs && bwe && !boe) e_rb = m_mem[bad];
    e_fa = flag_next(e_fa, bwr && bad == MB_A, !acs && !aoe && aad == MB_A);
    e_fb = flag_next(e_fb, awr && aad == MB_B, !bcs && !boe && bad == MB_B);
    if (bwr && !(awr && aad == bad)) m_mem[bad] = bwd;
    if (awr) m_mem[aad] = awd;
    @(posedge clk);
    @(negedge clk);
    check({tag, " a_irq_n"}, DW'(a_irq_n), DW'(!e_fa));
    check({tag, " b_irq_n"}, DW'(b_irq_n), DW'(!e_fb));
    check("R9 a_rdata", a_rdata, e_ra);
    check("R9 b_rdata", b_rdata, e_rb);
    check("R8 off a_irq_n", DW'(o_a_irq_n), DW'(1'b1));
    check("R8 off b_irq_n", DW'(o_b_irq_n), DW'(1'b1));
    check("R8 off a_rdata", o_a_rdata, e_ra);
    check("R8 off b_rdata", o_b_rdata, e_rb);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired got=running exp=done");
    summary();
  end

  function automatic logic [AW-1:0] pick_addr();
    int unsigned r = $urandom % 4;
    if (r == 0) return MB_A;
    if (r == 1) return MB_B;
    return AW'($urandom % 8);
  endfunction

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 a_irq_n", DW'(a_irq_n), DW'(1'b1));
    check("R1 b_irq_n", DW'(b_irq_n), DW'(1'b1));
    check("R1 a_rdata", a_rdata, '0);
    check("R1 b_rdata", b_rdata, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: port B posts a message to port A's mailbox
    step(1,1,1,0,0,        0,1,0,MB_A,16'h1234, "R2");
    // R10: owner touches other address, or own mailbox with oe_n high
    step(0,0,1,5,0,        1,1,1,0,0,           "R10");
    step(0,1,1,MB_A,0,     1,1,1,0,0,           "R10");
    // R3 and R7: owner reads its mailbox, flag clears, data is the message
    step(0,0,1,MB_A,0,     1,1,1,0,0,           "R3 R7");
    // R4: port A posts to port B's mailbox
    step(0,1,0,MB_B,16'hBEEF, 1,1,1,0,0,        "R4");
    // R6: set and clear of A's flag in the same cycle
    step(0,0,1,MB_A,0,     0,1,0,MB_A,16'h5A5A, "R6");
    // R6: same collision on B's flag
    step(0,1,0,MB_B,16'hC0DE, 0,0,1,MB_B,0,     "R6");
    // R3: access with write strobe low still clears
    step(0,0,0,MB_A,16'h7777, 1,1,1,0,0,        "R3");
    // R5 and R7: port B reads its mailbox
    step(1,1,1,0,0,        0,0,1,MB_B,0,        "R5 R7");
    step(0,0,1,MB_A,0,     1,1,1,0,0,           "R7");
    // R9: simultaneous write to one address, port A wins
    step(0,1,0,7,16'hAAAA, 0,1,0,7,16'h5555,    "R9");
    step(0,0,1,7,0,        0,0,1,7,0,           "R9");

    for (int i = 0; i < 3000; i++) begin
      step($urandom % 4 == 0, $urandom % 2, $urandom % 2, pick_addr(), DW'($urandom),
           $urandom % 4 == 0, $urandom % 2, $urandom % 2, pick_addr(), DW'($urandom),
           "R2/R3/R4/R5/R6/R10");
    end
    summary();
  end
endmodule